// File: doc/BRIEF.md
# Smart card character transmitter

This block drives one character at a time onto the half-duplex I/O line of a smart card and raises an end-of-transmission flag at a point measured in elementary time units (etu). The etu length is the product of two settings. A prescaler divides the system clock, and a base count then sets how many prescaled clocks make one etu. The end point is programmable. It falls at 12.5 etu in normal mode, 11.5 etu in block mode and 11.0 etu with the GSM timing variant.

The block also produces the card clock. The clock can be switched on and off. When the GSM variant is selected, the clock can also be held at a fixed high or fixed low level.

A user sets the configuration inputs, places a byte on the data input and pulses the start strobe while the end flag is high. The frame is a low start bit, eight data bits sent LSB first and a parity bit. After the parity bit the line returns high. Internally, timing runs on half-etu ticks, so that the half-etu end points fall on exact cycles.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, `tx_end_o` is 1, `io_o` is 1 and `cfg_err_o` is 0.
- R2: A start strobe is accepted only while `tx_end_o` is 1. On the first clock edge where the strobe is accepted, `tx_end_o` goes to 0 and `io_o` goes low. A strobe that arrives while `tx_end_o` is 0 changes neither the frame in progress nor its end time.
- R3: The frame on `io_o` has a fixed order. Bit slot 0 is the low start bit. Slots 1 to 8 carry data bits 0 to 7, LSB first. Slot 9 carries parity. Each slot lasts one etu, counted from the accepting edge. From slot 10 onward, and whenever `tx_end_o` is 1, the line is high.
- R4: The parity sense is set by `par_odd_i`. With 0 (even), the eight data bits and the parity bit together hold an even number of ones. With 1 (odd), they hold an odd number.
- R5: `cks_sel_i` selects the prescaler ratio. Codes 0, 1, 2 and 3 divide the system clock by 1, 4, 16 and 64.
- R6: `etu_sel_i` selects the base count. Codes 0, 1, 2 and 3 give 32, 64, 372 and 256 prescaled clocks per etu.
- R7: With `gsm_mode_i`=0 and `blk_mode_i`=0, `tx_end_o` rises 12.5 etu after the accepting edge.
- R8: With `gsm_mode_i`=0 and `blk_mode_i`=1, `tx_end_o` rises 11.5 etu after the accepting edge.
- R9: With `gsm_mode_i`=1, `tx_end_o` rises 11.0 etu after the accepting edge, whatever the value of `blk_mode_i`.
- R10: A start accepted with `par_en_i`=0 sets `cfg_err_o` to 1, one edge after acceptance. A start accepted with `par_en_i`=1 clears it. Between accepted starts, `cfg_err_o` holds its value.
- R11: `cks_sel_i`, `etu_sel_i`, `par_odd_i`, `blk_mode_i`, `gsm_mode_i` and `data_i` are captured on the accepting edge. Changing them during a frame has no effect on that frame.
- R12: With `gsm_mode_i`=0, `card_clk_o` is 0 whenever `cclk_en_i` is 0, and the force inputs have no effect. With `gsm_mode_i`=1 and `cclk_force_i`=1, `card_clk_o` equals `cclk_level_i` one edge later.
- R13: With the clock running and not forced, `card_clk_o` toggles once per prescaled tick, using the live value of `cks_sel_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cks_sel_i | input | 2 | Prescaler select |
| etu_sel_i | input | 2 | Base count select |
| par_odd_i | input | 1 | 1 selects odd parity |
| par_en_i | input | 1 | Parity enable; must be 1 |
| blk_mode_i | input | 1 | Block transfer timing |
| gsm_mode_i | input | 1 | GSM timing and clock forcing |
| cclk_en_i | input | 1 | Card clock on |
| cclk_force_i | input | 1 | Hold card clock at fixed level (GSM only) |
| cclk_level_i | input | 1 | Fixed card clock level |
| data_i | input | 8 | Character to send |
| start_i | input | 1 | Start strobe |
| io_o | output | 1 | Serial I/O line |
| tx_end_o | output | 1 | Transmission end flag |
| cfg_err_o | output | 1 | Parity-disabled configuration error |
| card_clk_o | output | 1 | Card clock output |

## Verification
The bench builds the block with its default parameters: base counts 32, 64, 372 and 256, and a prescaler that steps by a factor of four per code. Most frames use the short base count, so every bit slot and every end point in all three timing modes stays within a few thousand cycles. Two frames reach the extremes: the 372 base count at division 1 and the divide-by-64 prescaler at base 32. These show that the odd-sized etu and the widest prescaler both land on the exact half-etu cycle.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned END_HALF_NORM = 25;
  localparam int unsigned END_HALF_BLK = 23;
  localparam int unsigned END_HALF_GSM = 22;

  typedef struct packed {
    logic [1:0] cks;
    logic [1:0] etu;
    logic       odd;
    logic       blk;
    logic       gsm;
  } tx_cfg_t;

  function automatic logic [IDX_W-1:0] end_halves(input logic blk, input logic gsm);
    if (gsm) return IDX_W'(END_HALF_GSM);
    if (blk) return IDX_W'(END_HALF_BLK);
    return IDX_W'(END_HALF_NORM);
  endfunction
endpackage

// File: rtl/sc_tx_prescale.sv
module sc_tx_prescale #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  input  logic             run_i,
  output logic             tick_o
);
  localparam int unsigned MAX_SH = STEP * ((1 << SEL_W) - 1);
  localparam int unsigned CNT_W  = (MAX_SH > 0) ? MAX_SH : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb lim = CNT_W'((64'd1 << (STEP * 32'(sel_i))) - 64'd1);
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R5
  div1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && sel_i == '0) |-> tick_o);
endmodule

// File: rtl/sc_tx_etu_timer.sv
module sc_tx_etu_timer #(
  parameter int unsigned ETU_B0 = 32,
  parameter int unsigned ETU_B1 = 64,
  parameter int unsigned ETU_B2 = 372,
  parameter int unsigned ETU_B3 = 256,
  parameter int unsigned IDX_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       etu_sel_i,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic             half_tick_o,
  output logic [IDX_W-1:0] half_idx_o
);
  localparam int unsigned M01 = (ETU_B0 > ETU_B1) ? ETU_B0 : ETU_B1;
  localparam int unsigned M23 = (ETU_B2 > ETU_B3) ? ETU_B2 : ETU_B3;
  localparam int unsigned MAX_B = (M01 > M23) ? M01 : M23;
  localparam int unsigned HALF_W = (MAX_B > 3) ? $clog2(MAX_B / 2) : 1;

  logic [HALF_W-1:0] hcnt_q;
  logic [HALF_W-1:0] hlim;
  logic [IDX_W-1:0]  idx_q;

  // half etu = base/2 prescaled ticks; bases must be even
  always_comb begin
    unique case (etu_sel_i)
      2'd0:    hlim = HALF_W'(ETU_B0 / 2 - 1);
      2'd1:    hlim = HALF_W'(ETU_B1 / 2 - 1);
      2'd2:    hlim = HALF_W'(ETU_B2 / 2 - 1);
      default: hlim = HALF_W'(ETU_B3 / 2 - 1);
    endcase
  end

  assign half_tick_o = run_i && tick_i && (hcnt_q >= hlim);
  assign half_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      idx_q  <= '0;
    end else if (clr_i) begin
      hcnt_q <= '0;
      idx_q  <= '0;
    end else if (run_i && tick_i) begin
      if (hcnt_q >= hlim) begin
        hcnt_q <= '0;
        idx_q  <= idx_q + 1'b1;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  // R6
  half_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |-> (hcnt_q <= hlim));
endmodule

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_i,
  input  logic              step_i,
  output logic              io_o
);
  logic [DATA_W:0] sh_q;
  logic            io_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
      io_q <= 1'b1;
    end else if (load_i) begin
      sh_q <= {(^data_i) ^ odd_i, data_i};
      io_q <= 1'b0;
    end else if (step_i) begin
      io_q <= sh_q[0];
      sh_q <= {1'b1, sh_q[DATA_W:1]};
    end
  end

  assign io_o = io_q;

  // R2
  load_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !io_o);
endmodule

// File: rtl/sc_card_clk.sv
module sc_card_clk #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] cks_sel_i,
  input  logic             gsm_i,
  input  logic             en_i,
  input  logic             force_i,
  input  logic             level_i,
  output logic             card_clk_o
);
  logic tick;
  logic tgl_q;
  logic out_q;

  sc_tx_prescale #(.SEL_W(SEL_W), .STEP(STEP)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cks_sel_i),
    .clr_i  (1'b0),
    .run_i  (1'b1),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (tick) tgl_q <= ~tgl_q;
      if (gsm_i && force_i) out_q <= level_i;
      else                  out_q <= en_i & tgl_q;
    end
  end

  assign card_clk_o = out_q;

  // R12
  force_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gsm_i && force_i) |=> (card_clk_o == $past(level_i)));
  // R12
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gsm_i && !en_i) |=> !card_clk_o);
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int unsigned ETU_B0 = 32,
  parameter int unsigned ETU_B1 = 64,
  parameter int unsigned ETU_B2 = 372,
  parameter int unsigned ETU_B3 = 256,
  parameter int unsigned PRE_STEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cks_sel_i,
  input  logic [1:0]        etu_sel_i,
  input  logic              par_odd_i,
  input  logic              par_en_i,
  input  logic              blk_mode_i,
  input  logic              gsm_mode_i,
  input  logic              cclk_en_i,
  input  logic              cclk_force_i,
  input  logic              cclk_level_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  output logic              io_o,
  output logic              tx_end_o,
  output logic              cfg_err_o,
  output logic              card_clk_o
);
  tx_cfg_t          cfg_q;
  logic             busy_q;
  logic             tx_end_q;
  logic             cfg_err_q;
  logic             accept;
  logic             tick;
  logic             half_tick;
  logic [IDX_W-1:0] half_idx;
  logic [IDX_W-1:0] next_idx;
  logic             bit_step;
  logic             done;

  assign accept   = start_i && tx_end_q;
  assign next_idx = half_idx + 1'b1;
  assign bit_step = half_tick && !next_idx[0];
  assign done     = half_tick && (next_idx == end_halves(cfg_q.blk, cfg_q.gsm));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      busy_q    <= 1'b0;
      tx_end_q  <= 1'b1;
      cfg_err_q <= 1'b0;
    end else if (accept) begin
      cfg_q     <= '{cks: cks_sel_i, etu: etu_sel_i, odd: par_odd_i,
                    blk: blk_mode_i, gsm: gsm_mode_i};
      busy_q    <= 1'b1;
      tx_end_q  <= 1'b0;
      cfg_err_q <= ~par_en_i;
    end else if (done) begin
      busy_q   <= 1'b0;
      tx_end_q <= 1'b1;
    end
  end

  sc_tx_prescale #(.SEL_W(2), .STEP(PRE_STEP)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (cfg_q.cks),
    .clr_i  (accept),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  sc_tx_etu_timer #(
    .ETU_B0(ETU_B0), .ETU_B1(ETU_B1), .ETU_B2(ETU_B2), .ETU_B3(ETU_B3), .IDX_W(IDX_W)
  ) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .etu_sel_i   (cfg_q.etu),
    .clr_i       (accept),
    .run_i       (busy_q),
    .tick_i      (tick),
    .half_tick_o (half_tick),
    .half_idx_o  (half_idx)
  );

  sc_tx_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (data_i),
    .odd_i  (par_odd_i),
    .step_i (bit_step),
    .io_o   (io_o)
  );

  sc_card_clk #(.SEL_W(2), .STEP(PRE_STEP)) u_cclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cks_sel_i  (cks_sel_i),
    .gsm_i      (gsm_mode_i),
    .en_i       (cclk_en_i),
    .force_i    (cclk_force_i),
    .level_i    (cclk_level_i),
    .card_clk_o (card_clk_o)
  );

  assign tx_end_o  = tx_end_q;
  assign cfg_err_o = cfg_err_q;

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_end_o && start_i) |=> (!tx_end_o && !io_o));
  // R11
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_end_o && start_i) |=> $stable(cfg_q));
  // R3
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> io_o);
  // R10
  cfg_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_end_o && start_i) |=> (cfg_err_o == !$past(par_en_i)));
  // R7
  end_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_end_o |-> (half_idx < IDX_W'(END_HALF_NORM)));
endmodule

// File: tb/sim_sc_char_tx.sv
`timescale 1ns/1ps
module sim_sc_char_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] cks_sel_i = '0;
  logic [1:0] etu_sel_i = '0;
  logic       par_odd_i = 1'b0;
  logic       par_en_i = 1'b1;
  logic       blk_mode_i = 1'b0;
  logic       gsm_mode_i = 1'b0;
  logic       cclk_en_i = 1'b0;
  logic       cclk_force_i = 1'b0;
  logic       cclk_level_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       start_i = 1'b0;
  logic       io_o, tx_end_o, cfg_err_o, card_clk_o;

  int checks = 0;
  int failures = 0;
  int cur = 0;

  always #2 clk_i = ~clk_i;

  sc_char_tx u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cks_sel_i(cks_sel_i), .etu_sel_i(etu_sel_i),
    .par_odd_i(par_odd_i), .par_en_i(par_en_i), .blk_mode_i(blk_mode_i),
    .gsm_mode_i(gsm_mode_i), .cclk_en_i(cclk_en_i), .cclk_force_i(cclk_force_i),
    .cclk_level_i(cclk_level_i), .data_i(data_i), .start_i(start_i),
    .io_o(io_o), .tx_end_o(tx_end_o), .cfg_err_o(cfg_err_o), .card_clk_o(card_clk_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_to(input int t);
    while (cur < t) begin
      @(posedge clk_i);
      cur++;
    end
    @(negedge clk_i);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [1:0] cks, input logic [1:0] etu,
                           input logic odd, input logic pen, input logic blk, input logic gsm,
                           input bit disturb, input string tag);
    int base, e, h, n;
    logic exp;
    base = (etu == 0) ? 32 : (etu == 1) ? 64 : (etu == 2) ? 372 : 256;
    e = base * (1 << (2 * cks));
    h = e / 2;
    n = gsm ? 22 : (blk ? 23 : 25);
    @(negedge clk_i);
    data_i = d; cks_sel_i = cks; etu_sel_i = etu; par_odd_i = odd;
    par_en_i = pen; blk_mode_i = blk; gsm_mode_i = gsm; start_i = 1'b1;
    @(posedge clk_i);
    cur = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(tx_end_o, 1'b0, "R2 accept");
    chk(cfg_err_o, !pen, "R10");
    for (int k = 0; k < 10; k++) begin
      wait_to(k * e + h);
      if (k == 0)      exp = 1'b0;
      else if (k < 9)  exp = d[k-1];
      else             exp = (^d) ^ odd;
      chk(io_o, exp, (k == 9) ? "R4 parity" : "R3 bit");
      if (disturb && k == 2) begin
        start_i = 1'b1; data_i = ~d; etu_sel_i = etu ^ 2'd1; cks_sel_i = cks ^ 2'd1;
        par_odd_i = !odd; blk_mode_i = !blk; gsm_mode_i = !gsm; par_en_i = !pen;
      end
      if (disturb && k == 5) start_i = 1'b0;
    end
    wait_to(10 * e + h);
    chk(io_o, 1'b1, "R3 stop high");
    wait_to(n * h - 1);
    chk(tx_end_o, 1'b0, tag);
    wait_to(n * h);
    chk(tx_end_o, 1'b1, tag);
    chk(io_o, 1'b1, "R3 idle");
    if (disturb) chk(cfg_err_o, !pen, "R11 err held");
    start_i = 1'b0; par_en_i = 1'b1; blk_mode_i = 1'b0; gsm_mode_i = 1'b0;
    cks_sel_i = '0; etu_sel_i = '0; par_odd_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(tx_end_o, 1'b1, "R1 tx_end");
    chk(io_o, 1'b1, "R1 io");
    chk(cfg_err_o, 1'b0, "R1 cfg_err");
  endtask

  task automatic t_frames;
    run_frame(8'hA5, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R7 normal end");
    run_frame(8'h3C, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R4 odd frame");
    run_frame(8'h01, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R4 even frame");
    run_frame(8'hFE, 2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R4 odd frame 2");
  endtask

  task automatic t_rates;
    run_frame(8'h5A, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R5 div4");
    run_frame(8'hC3, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R5 div16");
    run_frame(8'h81, 2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R5 div64");
    run_frame(8'h7E, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R6 base64");
    run_frame(8'h96, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R6 base372");
    run_frame(8'h69, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R6 base256");
  endtask

  task automatic t_modes;
    run_frame(8'h12, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 0, "R8 block end");
    run_frame(8'h34, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 0, "R9 gsm end");
    run_frame(8'h56, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 0, "R9 gsm+block end");
  endtask

  task automatic t_ignore;
    run_frame(8'hB4, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R2 R11 mid-frame start");
    run_frame(8'h4B, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1, "R2 R11 mid-frame start blk");
  endtask

  task automatic t_cfg_err;
    run_frame(8'h0F, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10 err frame");
    chk(cfg_err_o, 1'b1, "R10 held");
    run_frame(8'hF0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R10 clear frame");
    chk(cfg_err_o, 1'b0, "R10 cleared");
  endtask

  task automatic count_toggles(input int cyc, output int n);
    logic prev;
    n = 0;
    @(negedge clk_i);
    prev = card_clk_o;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (card_clk_o != prev) n++;
      prev = card_clk_o;
    end
  endtask

  task automatic t_card_clk;
    int n;
    bit bad;
    @(negedge clk_i);
    gsm_mode_i = 1'b0; cclk_en_i = 1'b0; cclk_force_i = 1'b1; cclk_level_i = 1'b1;
    repeat (2) @(negedge clk_i);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (card_clk_o) bad = 1;
    end
    chk(bad, 1'b0, "R12 force ignored without gsm");
    gsm_mode_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(card_clk_o, 1'b1, "R12 forced high");
    cclk_level_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(card_clk_o, 1'b0, "R12 forced low");
    cclk_force_i = 1'b0; cclk_en_i = 1'b1; cks_sel_i = 2'd0;
    repeat (3) @(negedge clk_i);
    count_toggles(16, n);
    chk(n == 16, 1'b1, "R13 div1 toggles");
    if (n != 16) $display("FAIL R13 actual=%0d expected=16", n);
    cks_sel_i = 2'd1;
    repeat (8) @(negedge clk_i);
    count_toggles(16, n);
    chk(n == 4, 1'b1, "R13 div4 toggles");
    if (n != 4) $display("FAIL R13 actual=%0d expected=4", n);
    gsm_mode_i = 1'b0;
    repeat (8) @(negedge clk_i);
    count_toggles(16, n);
    chk(n == 4, 1'b1, "R12 on without gsm");
    cclk_en_i = 1'b0; cks_sel_i = 2'd0;
    repeat (2) @(negedge clk_i);
    chk(card_clk_o, 1'b0, "R12 off");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_frames();
    t_rates();
    t_modes();
    t_ignore();
    t_cfg_err();
    t_card_clk();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule